// File: doc/BRIEF.md
# Byte-Parity Guarded Configuration Register

This block holds one configuration word and protects every byte of it with its own stored parity bit. Each stored byte is checked against its stored parity on every cycle. The combined result is driven on a single error output, which a system-level monitor can watch. A normal write uses byte enables. For each enabled byte, the write stores the new data and computes a fresh parity bit for it.

A separate 4-bit key register controls a test view. While the key holds the unlock value 1010, a read no longer returns the stored word. Instead, bit 0 of each byte shows whether that byte currently fails its parity check, and the other bits read as zero. In this state a write never changes the stored data. A 1 written to bit 0 of an enabled byte flips that byte's stored parity bit, so software can plant an error and confirm that the error path works. Writing the 1 again removes the error. A normal write to the byte also removes it.

Top module: `parity_guarded_reg`

## Requirements
- R1: After reset the read port returns all zeros, the key reads 0000, and the error output is low.
- R2: When the test view is off, a write stores data only into the bytes whose enable is high. Other bytes keep their value. The read port shows the new word in the cycle after the write edge.
- R3: Parity is even (stored bit = XOR of the byte). After any write with the test view off, the written bytes report no parity error.
- R4: The test view is on only while the key equals 1010. With the key at 0000, 0101 or any other value, reads return the stored data.
- R5: With the test view on, byte i of the read word holds that byte's error result at bit position 8*i. All other bits read 0.
- R6: With the test view on, a write with enable i high and bit 8*i set to 1 inverts byte i's stored parity. The error result of that byte toggles after the write edge.
- R7: With the test view on, writes never change the stored data. A write whose bit 8*i is 0, or whose enable i is low, leaves byte i's parity unchanged.
- R8: The error output is the OR of the four byte error results. It is combinational and is active whether the test view is on or off.
- R9: A write with the test view off to a byte that has an injected error clears that byte's error.
- R10: A key write loads the 4-bit key, which reads back on the key output after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the guarded word |
| wr_be | input | 4 | Per-byte write enables |
| wr_data | input | 32 | Write data |
| key_wr_en | input | 1 | Write strobe for the test key |
| key_wr_data | input | 4 | New test key value |
| key_q | output | 4 | Current test key |
| rd_data | output | 32 | Read view: stored word, or per-byte error flags in the test view |
| par_err | output | 1 | OR of all byte parity errors |

## Verification
The assertions assume that the key and a data write do not change the test view and the data in the same cycle in a way that creates ambiguity. The properties sample the test view as registered at the write edge, which is how the design decides what a write does, so this holds for any stimulus. They also assume that the stored contents change only through the write port. The bench drives every input on the falling clock edge and holds it for one full cycle. It never changes the key and writes the word in the same cycle, so each check has a single defined expected value.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

  // Even parity of one byte lane: the stored bit makes the total count of ones even.
  function automatic logic even_par8(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/pgr_key_reg.sv
module pgr_key_reg #(
  parameter int          KEY_W    = 4,
  parameter logic [3:0]  KEY_OPEN = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [KEY_W-1:0] d,
  output logic [KEY_W-1:0] key_q,
  output logic             test_on
);

  logic [KEY_W-1:0] key_d;

  always_comb begin
    key_d = key_q;
    if (ld) key_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  // Only the exact unlock pattern opens the test view.
  assign test_on = (key_q == KEY_OPEN[KEY_W-1:0]);

endmodule

// File: rtl/pgr_lane.sv
module pgr_lane
  import pgr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_on,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] data_q,
  output logic         err,
  output logic [W-1:0] view
);

  logic [W-1:0] data_d;
  logic         par_q;
  logic         par_d;

  always_comb begin
    data_d = data_q;
    par_d  = par_q;
    if (we) begin
      if (!test_on) begin
        data_d = d;
        par_d  = even_par8(d);
      end else if (d[0]) begin
        par_d = ~par_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      par_q  <= par_d;
    end
  end

  assign err  = even_par8(data_q) ^ par_q;
  assign view = test_on ? {{(W-1){1'b0}}, err} : data_q;

endmodule

// File: rtl/pgr_err_merge.sv
module pgr_err_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] lane_err,
  output logic         any_err
);

  always_comb begin
    any_err = 1'b0;
    for (int i = 0; i < N; i++) any_err = any_err | lane_err[i];
  end

endmodule

// File: rtl/parity_guarded_reg.sv
module parity_guarded_reg #(
  parameter int          NBYTES   = 4,
  parameter int          KEY_W    = 4,
  parameter logic [3:0]  KEY_OPEN = 4'b1010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NBYTES-1:0]     wr_be,
  input  logic [NBYTES*8-1:0]   wr_data,
  input  logic                  key_wr_en,
  input  logic [KEY_W-1:0]      key_wr_data,
  output logic [KEY_W-1:0]      key_q,
  output logic [NBYTES*8-1:0]   rd_data,
  output logic                  par_err
);

  localparam int BYTE_W = 8;
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              test_on;
  logic [DATA_W-1:0] data_all;
  logic [NBYTES-1:0] err_vec;

  pgr_key_reg #(
    .KEY_W    (KEY_W),
    .KEY_OPEN (KEY_OPEN)
  ) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (key_wr_en),
    .d       (key_wr_data),
    .key_q   (key_q),
    .test_on (test_on)
  );

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    pgr_lane #(
      .W (BYTE_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .test_on (test_on),
      .we      (wr_en & wr_be[g]),
      .d       (wr_data[g*BYTE_W +: BYTE_W]),
      .data_q  (data_all[g*BYTE_W +: BYTE_W]),
      .err     (err_vec[g]),
      .view    (rd_data[g*BYTE_W +: BYTE_W])
    );
  end

  pgr_err_merge #(
    .N (NBYTES)
  ) u_merge (
    .lane_err (err_vec),
    .any_err  (par_err)
  );

endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
  parameter int NBYTES = 4,
  parameter int KEY_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [NBYTES-1:0]   wr_be,
  input logic [NBYTES*8-1:0] wr_data,
  input logic                key_wr_en,
  input logic [KEY_W-1:0]    key_wr_data,
  input logic [KEY_W-1:0]    key_q,
  input logic                test_on,
  input logic [NBYTES*8-1:0] data_all,
  input logic [NBYTES-1:0]   err_vec,
  input logic [NBYTES*8-1:0] rd_data,
  input logic                par_err
);

  localparam int DATA_W = NBYTES * 8;

  function automatic logic [DATA_W-1:0] lsb_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NBYTES; i++) m[i*8] = 1'b1;
    return m;
  endfunction

  // R10: key loads on the write edge
  a_r10_key_load: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr_en |=> key_q == $past(key_wr_data));

  // R5: only bit 0 of each byte may be set in the test view
  a_r5_view_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |-> (rd_data & ~lsb_mask()) == '0);

  // R8: error output agrees with the per-byte flags seen in the test view
  a_r8_view_matches_out: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |-> par_err == (|(rd_data & lsb_mask())));

  // R3: full normal write leaves no parity error
  a_r3_clean_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !test_on && (&wr_be)) |=> !par_err);

  // R7: data held while writing in the test view
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && test_on) |=> $stable(data_all));

  for (genvar g = 0; g < NBYTES; g++) begin : g_chk
    // R2: enabled byte takes the new value on a normal write
    a_r2_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !test_on && wr_be[g]) |=> data_all[g*8 +: 8] == $past(wr_data[g*8 +: 8]));
    // R6: injection toggles the byte's error
    a_r6_inject_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && test_on && wr_be[g] && wr_data[g*8]) |=> err_vec[g] != $past(err_vec[g]));
  end

endmodule

bind parity_guarded_reg pgr_checker #(
  .NBYTES (NBYTES),
  .KEY_W  (KEY_W)
) u_pgr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_be       (wr_be),
  .wr_data     (wr_data),
  .key_wr_en   (key_wr_en),
  .key_wr_data (key_wr_data),
  .key_q       (key_q),
  .test_on     (test_on),
  .data_all    (data_all),
  .err_vec     (err_vec),
  .rd_data     (rd_data),
  .par_err     (par_err)
);

// File: tb/parity_guarded_reg_test.sv
module parity_guarded_reg_test;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        key_wr_en;
  logic [3:0]  key_wr_data;
  logic [3:0]  key_q;
  logic [31:0] rd_data;
  logic        par_err;

  int n_tests;
  int n_fail;

  // bench model
  logic [31:0] m_data;
  logic [3:0]  m_err;
  logic [3:0]  m_key;

  parity_guarded_reg uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .key_wr_en   (key_wr_en),
    .key_wr_data (key_wr_data),
    .key_q       (key_q),
    .rd_data     (rd_data),
    .par_err     (par_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] view_of(input logic [3:0] e);
    return {7'b0, e[3], 7'b0, e[2], 7'b0, e[1], 7'b0, e[0]};
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_model(input string req);
    logic [31:0] exp_rd;
    exp_rd = (m_key == 4'b1010) ? view_of(m_err) : m_data;
    check32({req, " rd_data"}, rd_data, exp_rd);
    check32({req, " par_err"}, {31'b0, par_err}, {31'b0, |m_err});
  endtask

  // drive at falling edge, commit on rising edge, return at next falling edge
  task automatic do_write(input logic [3:0] be, input logic [31:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        if (m_key == 4'b1010) begin
          if (d[i*8]) m_err[i] = ~m_err[i];
        end else begin
          m_data[i*8 +: 8] = d[i*8 +: 8];
          m_err[i] = 1'b0;
        end
      end
    end
  endtask

  task automatic do_key(input logic [3:0] k);
    key_wr_en = 1'b1; key_wr_data = k;
    @(negedge clk);
    key_wr_en = 1'b0; key_wr_data = '0;
    m_key = k;
  endtask

  task automatic t_reset;
    check32("R1 rd_data", rd_data, 32'h0);
    check32("R1 par_err", {31'b0, par_err}, 32'h0);
    check32("R1 key_q", {28'b0, key_q}, 32'h0);
  endtask

  task automatic t_normal;
    do_write(4'b1111, 32'h1234_5678);
    check_model("R2 full write");
    check32("R2 value", rd_data, 32'h1234_5678);
    do_write(4'b0101, 32'hAABB_CCDD);
    check32("R2 partial write", rd_data, 32'h12BB_56DD);
    check32("R3 no error after writes", {31'b0, par_err}, 32'h0);
    do_write(4'b1010, 32'h0F07_0301);
    check_model("R3 odd-weight bytes");
  endtask

  task automatic t_keys;
    do_key(4'b0101);
    check32("R10 key readback", {28'b0, key_q}, 32'h5);
    check_model("R4 key 0101");
    do_key(4'b0000);
    check_model("R4 key 0000");
    do_key(4'b1011);
    check_model("R4 key 1011");
    do_key(4'b1010);
    check32("R5 clean test view", rd_data, 32'h0);
    check32("R10 key open", {28'b0, key_q}, 32'hA);
  endtask

  task automatic t_inject;
    // still in test view
    do_write(4'b1111, 32'h0000_0100);
    check32("R6 inject byte1", rd_data, 32'h0000_0100);
    check32("R8 par_err test view", {31'b0, par_err}, 32'h1);
    do_write(4'b1111, 32'hFEFE_FEFE);
    check_model("R7 zero bit0 no effect");
    do_write(4'b1011, 32'h0101_0101);
    check_model("R7 disabled byte2 no effect");
    check32("R6 bytes 0,1,3", rd_data, view_of(4'b1001));
    do_write(4'b0101, 32'h0101_0101);
    check32("R6 toggle 0 and 2", rd_data, view_of(4'b1100));
    do_key(4'b0000);
    check32("R7 data unchanged", rd_data, m_data);
    check32("R8 par_err normal view", {31'b0, par_err}, 32'h1);
    do_write(4'b0100, 32'h0033_0000);
    check_model("R9 repair byte2");
    do_write(4'b1000, 32'h4400_0000);
    check_model("R9 repair byte3");
    check32("R9 all clear", {31'b0, par_err}, 32'h0);
  endtask

  task automatic t_retoggle;
    do_key(4'b1010);
    do_write(4'b1000, 32'h0100_0000);
    check32("R6 set byte3", rd_data, 32'h0100_0000);
    do_write(4'b1000, 32'h0100_0000);
    check32("R6 clear byte3", rd_data, 32'h0);
    check32("R8 cleared", {31'b0, par_err}, 32'h0);
    do_key(4'b0101);
    check_model("R4 exit with 0101");
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    m_data = '0; m_err = '0; m_key = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    key_wr_en = 1'b0; key_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_keys();
    t_inject();
    t_retoggle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule